// File: doc/BRIEF.md
# UART FIFO Controller with DMA Requests

This block sits between the serial shift logic of a UART and the system bus. It holds one byte queue for received characters and one for characters waiting to be sent, plus the control register that governs both. The receiver pushes bytes into the receive queue and the bus side pops them. The bus side pushes bytes into the transmit queue and the transmitter pops them. Both pop ports show the head byte before the pop.

The control register is written through a single-cycle write strobe. Its enable bit turns both queues on together. Any change of that bit empties both queues. Two self-clearing strobe bits empty one queue each. A DMA mode bit, two trigger bits and the enable bit decide when the block raises its two DMA request lines.

The transmit request is raised while the transmit queue has room. The receive request is raised when the receive level reaches the programmed trigger. It is also raised when a character timeout fires, which catches a short tail of data that never reaches the trigger.

A small state machine tracks the timeout, using a character-time tick from the baud logic. Its states are TO_IDLE (the receive queue is empty), TO_COUNT (data is waiting and ticks are being counted) and TO_FIRED (the timeout has fired). Its transitions are:
- TO_IDLE to TO_COUNT when the queue becomes non-empty.
- TO_COUNT to TO_FIRED on the fourth quiet tick.
- TO_COUNT or TO_FIRED to TO_IDLE when the queue empties.
- TO_FIRED to TO_COUNT on any accepted push, accepted pop or flush. The same events clear the count while in TO_COUNT.

Top module: `uart_fifo_dma`

## Requirements
- R1: After reset the control register is all zero, both queues are empty with level 0, and both DMA requests are low.
- R2: Control bit 0 enables both queues. While it is clear, pushes and pops are ignored, and both levels stay 0.
- R3: Control bits 7:1 take the written value only when bit 0 is already set before the write. Otherwise a write updates bit 0 alone.
- R4: A write that changes bit 0, whether from 0 to 1 or from 1 to 0, leaves both queues empty after that clock edge.
- R5: With bit 0 set, writing bit 1 as 1 empties the receive queue and writing bit 2 as 1 empties the transmit queue. These strobes are not stored and do not flush again on later writes.
- R6: Each queue holds 16 bytes and returns them in first-in first-out order. A push into a full queue is ignored, and so is a pop from an empty queue. The full, empty and level outputs follow the contents each cycle. A push and a pop in the same cycle both take effect.
- R7: DMA requests are raised only while both bit 0 and bit 3 (DMA mode) are set.
- R8: In DMA mode the receive request is high whenever the receive level is at least the trigger. Bits 7:6 select the trigger as follows: 00 gives 1 byte, 01 gives 4 bytes, 10 gives 8 bytes and 11 gives 14 bytes.
- R9: In DMA mode the receive request is also high once the receive queue has stayed non-empty for 4 counted ticks with no accepted push, pop or flush. Ticks start counting from the second cycle after the queue becomes non-empty. The request stays high until a push, a pop or an empty queue clears the timeout.
- R10: In DMA mode the transmit request is high exactly when the transmit queue is not full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| rx_push | input | 1 | Push a received byte |
| rx_push_data | input | 8 | Received byte |
| rx_pop | input | 1 | Pop the head of the receive queue |
| rx_pop_data | output | 8 | Head of the receive queue |
| tx_push | input | 1 | Push a byte to send |
| tx_push_data | input | 8 | Byte to send |
| tx_pop | input | 1 | Pop the head of the transmit queue |
| tx_pop_data | output | 8 | Head of the transmit queue |
| char_tick | input | 1 | One-cycle pulse per character time |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_full | output | 1 | Receive queue full |
| rx_empty | output | 1 | Receive queue empty |
| rx_level | output | 5 | Receive queue level |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |
| tx_level | output | 5 | Transmit queue level |

## Verification
The assertions assume the following about the inputs:
- Reset is held across at least one clock edge.
- The queue depth is a power of two no smaller than the largest trigger.
- The tick, push, pop and write strobes are sampled as plain levels on each edge.

No legal input pattern can break the checked properties, so the assertions restrict nothing else about the inputs. The stimulus drives every input on the falling edge and issues at most one control write per cycle. On purpose, it mixes pushes into a full queue, pops from an empty queue, simultaneous push and pop, and writes that toggle the enable bit. This keeps the illegal-looking but legal corners inside the checked space.

// File: rtl/uf_pkg.sv
package uf_pkg;

    // Control register bit positions; software and the bench depend on them.
    localparam int unsigned CB_EN      = 0;
    localparam int unsigned CB_RXCLR   = 1;
    localparam int unsigned CB_TXCLR   = 2;
    localparam int unsigned CB_DMA     = 3;
    localparam int unsigned CB_TRIG_LO = 6;
    localparam int unsigned CB_TRIG_HI = 7;

    typedef enum logic [1:0] {
        TO_IDLE  = 2'd0,
        TO_COUNT = 2'd1,
        TO_FIRED = 2'd2
    } to_state_e;

    // Receive trigger selection to byte count.
    function automatic int unsigned trig_bytes(input logic [1:0] sel);
        unique case (sel)
            2'b00:   trig_bytes = 1;
            2'b01:   trig_bytes = 4;
            2'b10:   trig_bytes = 8;
            default: trig_bytes = 14;
        endcase
    endfunction

endpackage

// File: rtl/uf_fifo.sv
module uf_fifo #(
    parameter int unsigned DW    = 8,
    parameter int unsigned DEPTH = 16,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned LW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] rdata,
    output logic          full,
    output logic          empty,
    output logic [LW-1:0] level,
    output logic          accepted
);

    logic [DW-1:0] mem [DEPTH];
    logic [LW-1:0] wptr_q, rptr_q;
    logic          push_ok, pop_ok;

    assign level    = wptr_q - rptr_q;
    assign full     = (level == LW'(DEPTH));
    assign empty    = (level == '0);
    assign push_ok  = en && push && !full;
    assign pop_ok   = en && pop && !empty;
    assign accepted = push_ok || pop_ok;
    assign rdata    = mem[rptr_q[AW-1:0]];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
        end else if (flush) begin
            wptr_q <= '0;
            rptr_q <= '0;
        end else begin
            if (push_ok) wptr_q <= wptr_q + 1'b1;
            if (pop_ok)  rptr_q <= rptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok && !flush) mem[wptr_q[AW-1:0]] <= wdata;
    end

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH));

    // R6
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop && !flush) |=> full);

    // R4
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> empty);

endmodule

// File: rtl/uf_ctrl.sv
module uf_ctrl
    import uf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [7:0] wdata,
    output logic       fifo_en,
    output logic       dma_mode,
    output logic [1:0] trig_sel,
    output logic       rx_flush,
    output logic       tx_flush
);

    logic en_change;
    logic unused_bits;

    assign unused_bits = ^wdata[5:4];
    assign en_change   = we && (wdata[CB_EN] != fifo_en);
    assign rx_flush    = en_change || (we && fifo_en && wdata[CB_RXCLR]);
    assign tx_flush    = en_change || (we && fifo_en && wdata[CB_TXCLR]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fifo_en  <= 1'b0;
            dma_mode <= 1'b0;
            trig_sel <= 2'b00;
        end else if (we) begin
            fifo_en <= wdata[CB_EN];
            if (fifo_en) begin
                dma_mode <= wdata[CB_DMA];
                trig_sel <= wdata[CB_TRIG_HI:CB_TRIG_LO];
            end
        end
    end

    // R3
    locked_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_en |=> $stable(dma_mode) && $stable(trig_sel));

endmodule

// File: rtl/uf_timeout.sv
module uf_timeout
    import uf_pkg::*;
#(
    parameter int unsigned TICKS = 4,
    localparam int unsigned CW   = $clog2(TICKS + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic nonempty,
    input  logic activity,
    input  logic tick,
    output logic fired
);

    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    to_state_e     state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TO_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            TO_IDLE: begin
                if (nonempty) begin
                    state_d = TO_COUNT;
                    cnt_d   = '0;
                end
            end
            TO_COUNT: begin
                if (!nonempty) begin
                    state_d = TO_IDLE;
                end else if (activity) begin
                    cnt_d = '0;
                end else if (tick) begin
                    if (cnt_q == LAST) state_d = TO_FIRED;
                    else               cnt_d   = cnt_q + 1'b1;
                end
            end
            TO_FIRED: begin
                if (!nonempty) begin
                    state_d = TO_IDLE;
                end else if (activity) begin
                    state_d = TO_COUNT;
                    cnt_d   = '0;
                end
            end
            default: state_d = TO_IDLE;
        endcase
    end

    always_comb begin
        fired = (state_q == TO_FIRED);
    end

    // R9
    fired_has_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fired |-> $past(nonempty));

    // R9
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    // R9
    quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !nonempty |=> !fired);

endmodule

// File: rtl/uart_fifo_dma.sv
module uart_fifo_dma
    import uf_pkg::*;
#(
    parameter int unsigned DW        = 8,
    parameter int unsigned DEPTH     = 16,
    parameter int unsigned TO_TICKS  = 4,
    localparam int unsigned LW       = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [7:0]    cfg_wdata,
    input  logic          rx_push,
    input  logic [DW-1:0] rx_push_data,
    input  logic          rx_pop,
    output logic [DW-1:0] rx_pop_data,
    input  logic          tx_push,
    input  logic [DW-1:0] tx_push_data,
    input  logic          tx_pop,
    output logic [DW-1:0] tx_pop_data,
    input  logic          char_tick,
    output logic          rx_dma_req,
    output logic          tx_dma_req,
    output logic          rx_full,
    output logic          rx_empty,
    output logic [LW-1:0] rx_level,
    output logic          tx_full,
    output logic          tx_empty,
    output logic [LW-1:0] tx_level
);

    logic       fifo_en, dma_mode, rx_flush, tx_flush;
    logic [1:0] trig_sel;
    logic       rx_acc, tx_acc_unused, to_fired, dma_on, rx_at_trig;

    uf_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .wdata    (cfg_wdata),
        .fifo_en  (fifo_en),
        .dma_mode (dma_mode),
        .trig_sel (trig_sel),
        .rx_flush (rx_flush),
        .tx_flush (tx_flush)
    );

    uf_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rx_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (fifo_en),
        .flush    (rx_flush),
        .push     (rx_push),
        .wdata    (rx_push_data),
        .pop      (rx_pop),
        .rdata    (rx_pop_data),
        .full     (rx_full),
        .empty    (rx_empty),
        .level    (rx_level),
        .accepted (rx_acc)
    );

    uf_fifo #(.DW(DW), .DEPTH(DEPTH)) u_tx_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (fifo_en),
        .flush    (tx_flush),
        .push     (tx_push),
        .wdata    (tx_push_data),
        .pop      (tx_pop),
        .rdata    (tx_pop_data),
        .full     (tx_full),
        .empty    (tx_empty),
        .level    (tx_level),
        .accepted (tx_acc_unused)
    );

    uf_timeout #(.TICKS(TO_TICKS)) u_timeout (
        .clk      (clk),
        .rst_n    (rst_n),
        .nonempty (!rx_empty),
        .activity (rx_acc || rx_flush),
        .tick     (char_tick),
        .fired    (to_fired)
    );

    assign dma_on     = fifo_en && dma_mode;
    assign rx_at_trig = (rx_level >= LW'(trig_bytes(trig_sel)));
    assign rx_dma_req = dma_on && (rx_at_trig || to_fired);
    assign tx_dma_req = dma_on && !tx_full;

    // R7
    dma_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_en |-> !rx_dma_req && !tx_dma_req);

    // R4
    en_change_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(fifo_en) |-> rx_empty && tx_empty);

    // R10
    tx_full_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_full |-> !tx_dma_req);

    // R2
    disabled_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_en |=> rx_empty && tx_empty);

endmodule

// File: tb/uart_fifo_dma_bench.sv
`timescale 1ns/1ps
module uart_fifo_dma_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       we = 1'b0;
    logic [7:0] wd = '0;
    logic       rxpu = 1'b0, rxpo = 1'b0, txpu = 1'b0, txpo = 1'b0, tick = 1'b0;
    logic [7:0] rxpd = '0, txpd = '0;
    logic [7:0] rx_pop_data, tx_pop_data;
    logic       rx_dma_req, tx_dma_req, rx_full, rx_empty, tx_full, tx_empty;
    logic [4:0] rx_level, tx_level;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    logic [7:0] rxq[$];
    logic [7:0] txq[$];
    bit         m_en, m_dma;
    logic [1:0] m_trig;
    int         ms, mc;

    always #4 clk = ~clk;

    uart_fifo_dma u_uart_fifo_dma (
        .clk(clk), .rst_n(rst_n), .cfg_we(we), .cfg_wdata(wd),
        .rx_push(rxpu), .rx_push_data(rxpd), .rx_pop(rxpo), .rx_pop_data(rx_pop_data),
        .tx_push(txpu), .tx_push_data(txpd), .tx_pop(txpo), .tx_pop_data(tx_pop_data),
        .char_tick(tick), .rx_dma_req(rx_dma_req), .tx_dma_req(tx_dma_req),
        .rx_full(rx_full), .rx_empty(rx_empty), .rx_level(rx_level),
        .tx_full(tx_full), .tx_empty(tx_empty), .tx_level(tx_level)
    );

    function automatic int trig_of(input logic [1:0] s);
        case (s)
            2'b00:   return 1;
            2'b01:   return 4;
            2'b10:   return 8;
            default: return 14;
        endcase
    endfunction

    function automatic bit exp_rx_req();
        return m_en && m_dma && ((rxq.size() >= trig_of(m_trig)) || ms == 2);
    endfunction

    function automatic bit exp_tx_req();
        return m_en && m_dma && (txq.size() < 16);
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_update();
        bit rfl = 0, tfl = 0, ne, rpu_ok, rpo_ok, tpu_ok, tpo_ok, act;
        ne = rxq.size() != 0;
        if (we) begin
            if (wd[0] != m_en) begin rfl = 1; tfl = 1; end
            if (m_en && wd[1]) rfl = 1;
            if (m_en && wd[2]) tfl = 1;
        end
        rpu_ok = m_en && rxpu && rxq.size() < 16;
        rpo_ok = m_en && rxpo && ne;
        tpu_ok = m_en && txpu && txq.size() < 16;
        tpo_ok = m_en && txpo && txq.size() != 0;
        act = rpu_ok || rpo_ok || rfl;
        case (ms)
            0: if (ne) begin ms = 1; mc = 0; end
            1: if (!ne) ms = 0;
               else if (act) mc = 0;
               else if (tick) begin if (mc == 3) ms = 2; else mc++; end
            default: if (!ne) ms = 0;
               else if (act) begin ms = 1; mc = 0; end
        endcase
        if (rfl) rxq.delete();
        else begin
            if (rpo_ok) void'(rxq.pop_front());
            if (rpu_ok) rxq.push_back(rxpd);
        end
        if (tfl) txq.delete();
        else begin
            if (tpo_ok) void'(txq.pop_front());
            if (tpu_ok) txq.push_back(txpd);
        end
        if (we) begin
            if (m_en) begin m_dma = wd[3]; m_trig = wd[7:6]; end
            m_en = wd[0];
        end
    endtask

    task automatic compare_all();
        chk("R6 rx_level", rx_level, rxq.size());
        chk("R6 tx_level", tx_level, txq.size());
        chk("R6 rx_full", rx_full, rxq.size() == 16);
        chk("R6 tx_empty", tx_empty, txq.size() == 0);
        if (rxq.size() != 0) chk("R6 rx_data", rx_pop_data, rxq[0]);
        if (txq.size() != 0) chk("R6 tx_data", tx_pop_data, txq[0]);
        chk("R8/R9 rx_dma_req", rx_dma_req, exp_rx_req());
        chk("R10 tx_dma_req", tx_dma_req, exp_tx_req());
    endtask

    task automatic step();
        @(posedge clk);
        model_update();
        #1;
        compare_all();
        @(negedge clk);
        we = 0; rxpu = 0; rxpo = 0; txpu = 0; txpo = 0; tick = 0;
    endtask

    task automatic wr(input logic [7:0] v);
        we = 1; wd = v; step();
    endtask

    task automatic push_rx(input int n);
        for (int i = 0; i < n; i++) begin rxpu = 1; rxpd = 8'($urandom); step(); end
    endtask

    task automatic push_tx(input int n);
        for (int i = 0; i < n; i++) begin txpu = 1; txpd = 8'($urandom); step(); end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin tick = 1; step(); step(); end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", total - fails, total);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; fails++;
            $display("FAIL watchdog R1..R10 run actual=hung expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        m_en = 0; m_dma = 0; m_trig = 0; ms = 0; mc = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        // R1: reset state
        chk("R1 rx_level", rx_level, 0);
        chk("R1 tx_empty", tx_empty, 1);
        chk("R1 rx_dma_req", rx_dma_req, 0);
        chk("R1 tx_dma_req", tx_dma_req, 0);
        @(negedge clk);

        // R2: disabled queues ignore pushes
        push_rx(3); push_tx(2);
        chk("R2 rx_level disabled", rx_level, 0);
        chk("R2 tx_level disabled", tx_level, 0);

        // R3: bit 3 ignored while disabled, then writable
        wr(8'h09);
        chk("R3 dma bit ignored", tx_dma_req, 0);
        wr(8'h09);
        chk("R7 tx_dma_req in dma mode", tx_dma_req, 1);

        // R6/R10: fill the transmit queue, overfill, drain
        push_tx(17);
        chk("R6 tx overfill level", tx_level, 16);
        chk("R10 tx full drops request", tx_dma_req, 0);
        for (int i = 0; i < 16; i++) begin txpo = 1; step(); end
        txpo = 1; step();
        chk("R6 pop on empty", tx_level, 0);

        // R8: trigger 4 bytes
        wr(8'h49);
        push_rx(3);
        chk("R8 below trigger", rx_dma_req, 0);
        push_rx(1);
        chk("R8 at trigger", rx_dma_req, 1);
        rxpo = 1; step();
        chk("R8 dropped below trigger", rx_dma_req, 0);

        // R9: timeout with three bytes waiting
        step();
        ticks(3);
        chk("R9 three ticks", rx_dma_req, 0);
        ticks(1);
        chk("R9 fourth tick fires", rx_dma_req, 1);
        rxpo = 1; step();
        chk("R9 pop clears timeout", rx_dma_req, 0);
        rxpu = 1; rxpo = 1; rxpd = 8'h5A; step();
        chk("R6 push+pop level", rx_level, 2);

        // R5: strobes
        push_tx(2);
        wr(8'h4B);
        chk("R5 rx strobe clears rx", rx_level, 0);
        chk("R5 rx strobe keeps tx", tx_level, 2);
        push_rx(2);
        wr(8'h49);
        chk("R5 strobe not stored", rx_level, 2);
        wr(8'h4D);
        chk("R5 tx strobe clears tx", tx_level, 0);

        // R4/R7: disable flushes, requests gated
        push_rx(2); push_tx(2);
        wr(8'h48);
        chk("R4 disable flush rx", rx_level, 0);
        chk("R4 disable flush tx", tx_level, 0);
        chk("R7 gated tx_dma_req", tx_dma_req, 0);
        wr(8'h01);
        wr(8'hC9);
        // R8: trigger 14 bytes
        push_rx(13);
        chk("R8 trig14 below", rx_dma_req, 0);
        push_rx(1);
        chk("R8 trig14 reached", rx_dma_req, 1);
        push_tx(3);
        wr(8'hC8);
        wr(8'hC9);
        chk("R4 enable toggle flush", rx_level + tx_level, 0);

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 99) < 2) begin
                we = 1;
                wd = 8'($urandom);
                if ($urandom_range(0, 9) < 9) wd[0] = 1'b1;
                if ($urandom_range(0, 3) != 0) wd[3] = 1'b1;
            end
            rxpu = ($urandom_range(0, 3) == 0);
            rxpd = 8'($urandom);
            rxpo = ($urandom_range(0, 4) == 0);
            txpu = ($urandom_range(0, 2) == 0);
            txpd = 8'($urandom);
            txpo = ($urandom_range(0, 3) == 0);
            tick = ($urandom_range(0, 2) == 0);
            step();
        end

        done = 1;
        summary();
        $finish;
    end

endmodule